// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets a clocked host read and write a 32K-word by 24-bit asynchronous static RAM. It drives the memory's active-low select, write and output strobes and a 15-bit address. The 24-bit data bus is presented as separate outbound data, a tri-state enable and inbound data, so a pad buffer can be placed outside the block. Every interval the memory needs is a parameter counted in whole clock cycles. From these parameters the controller works out how long each phase of an access lasts, and it stretches the phases so that no access is shorter than the memory's minimum cycle time.

The host pulses `host_req` for one clock while the controller is idle. With the request it presents the address, the write flag and the write data. The controller accepts the request only when it is idle. It then runs one complete access and raises `host_ready` for exactly one clock when that access ends. For a read, the word is sampled on the last clock of the access phase and held on `host_rdata` until the next read completes. Between accesses all strobes are high and the data drivers are off.

Derived lengths used below, from the cycle parameters T_AS, T_WP, T_WZ, T_DS, T_DH, T_RD, T_OZ and T_CYC:
- SU = max(1,T_AS)
- PW = max(T_WP, T_WZ+max(1,T_DS))
- HD = max(1,T_DH,T_CYC-SU-PW)
- RD = max(1,T_RD)
- GAP = max(1,T_OZ,T_CYC-RD)

A write lasts SU+PW+HD clocks and a read lasts RD+GAP clocks.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, cs_n, we_n and oe_n are 1, mem_dq_oe is 0 and host_ready is 0.
- R2: A write starts with SU clocks in which cs_n=0, we_n=1, oe_n=1 and drivers are off. mem_addr holds the accepted address and does not change while cs_n is 0.
- R3: After the setup clocks, we_n is 0 for exactly PW clocks with cs_n=0. oe_n stays 1 for the whole write.
- R4: During the write pulse, mem_dq_oe stays 0 for the first T_WZ clocks and is 1 for the rest. While driven, mem_dq_out holds the accepted write data, so data is on the bus for at least T_DS clocks before the write ends.
- R5: The write ends with we_n and cs_n rising on the same clock. Address and data stay driven for HD clocks afterwards, and the word present at that edge is the one stored.
- R6: A read holds cs_n=0, oe_n=0 and we_n=1 for RD clocks. host_rdata takes the bus value sampled on the last of those clocks and keeps it through later writes until the next read ends. A location never written reads as the model's zero.
- R7: After a read, all strobes are 1 and drivers off for GAP clocks. mem_dq_oe is never 1 while oe_n is 0, or within T_OZ clocks after oe_n was last 0.
- R8: host_ready is high for exactly one clock. It is high in the clock that follows the last clock of the access, which is SU+PW+HD+1 clocks after acceptance for a write and RD+GAP+1 for a read.
- R9: host_req, and every host input, is ignored while an access is in progress. The running access is unchanged, no extra ready pulse appears, and no location is written.
- R10: Whenever cs_n is 1, we_n and oe_n are also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-clock request pulse, taken only when idle |
| host_we | input | 1 | 1 = write, 0 = read, sampled with host_req |
| host_addr | input | 15 | Word address, sampled with host_req |
| host_wdata | input | 24 | Write data, sampled with host_req |
| host_rdata | output | 24 | Last read word, held until the next read ends |
| host_ready | output | 1 | One-clock pulse when an access completes |
| mem_addr | output | 15 | Address to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 24 | Data toward the memory |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dq_out |
| mem_dq_in | input | 24 | Data from the memory bus |

## Verification
The bench aims at the turnaround from a read straight into a write. A controller that drives too early there fights the memory's still-active outputs, and the monitor counts clocks since the memory last drove to catch it. It also checks the point where a read samples its data. Sampling one clock late picks up the floating-bus pattern instead of the stored word. Further checks cover requests arriving mid-access, which a careless sequencer would restart on or write to a stray address. They also cover the two ends of the address range, unwritten locations, and whether the read word stays unchanged across writes.

// File: rtl/asram_pkg.sv
package asram_pkg;

  // Phases of one memory access
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSETUP,
    PH_WPULSE,
    PH_WHOLD,
    PH_RACCESS,
    PH_RGAP
  } phase_e;

  // Pin-level strobe bundle (active-low strobes plus driver enable)
  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_span_counter.sv
// Counts clocks inside one phase; restarts whenever the phase changes.
module asram_span_counter #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] last_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             at_end
);

  assign at_end = (cnt_q == last_val);
  assign cnt_d  = restart ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/asram_seq.sv
// Phase sequencer: decides the next phase and flags accept/capture/finish.
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned SU_LEN  = 1,
  parameter int unsigned PW_LEN  = 4,
  parameter int unsigned HD_LEN  = 1,
  parameter int unsigned RD_LEN  = 4,
  parameter int unsigned GAP_LEN = 1,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_we,
  output phase_e           phase_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic             accept,
  output logic             capture,
  output logic             finish
);

  phase_e           phase_q;
  logic [CNT_W-1:0] last_val;
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;
  logic             restart;

  // Final count value for the phase now running
  always_comb begin
    unique case (phase_q)
      PH_WSETUP:  last_val = CNT_W'(SU_LEN - 1);
      PH_WPULSE:  last_val = CNT_W'(PW_LEN - 1);
      PH_WHOLD:   last_val = CNT_W'(HD_LEN - 1);
      PH_RACCESS: last_val = CNT_W'(RD_LEN - 1);
      PH_RGAP:    last_val = CNT_W'(GAP_LEN - 1);
      default:    last_val = '0;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    accept  = 1'b0;
    capture = 1'b0;
    finish  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req) begin
          accept  = 1'b1;
          phase_d = req_we ? PH_WSETUP : PH_RACCESS;
        end
      end
      PH_WSETUP:  if (at_end) phase_d = PH_WPULSE;
      PH_WPULSE:  if (at_end) phase_d = PH_WHOLD;
      PH_WHOLD: begin
        if (at_end) begin
          phase_d = PH_IDLE;
          finish  = 1'b1;
        end
      end
      PH_RACCESS: begin
        if (at_end) begin
          phase_d = PH_RGAP;
          capture = 1'b1;
        end
      end
      PH_RGAP: begin
        if (at_end) begin
          phase_d = PH_IDLE;
          finish  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign restart = (phase_d != phase_q) || (phase_q == PH_IDLE);

  asram_span_counter #(.CNT_W(CNT_W)) u_span (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .last_val (last_val),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .at_end   (at_end)
  );

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

endmodule

// File: rtl/asram_pin_regs.sv
// Registered memory pins and host result registers.
module asram_pin_regs
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned WZ_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase_d,
  input  logic [CNT_W-1:0]  cnt_d,
  input  logic              accept,
  input  logic              capture,
  input  logic              finish,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  strobe_t strb_d;
  strobe_t strb_q;

  // Pin pattern for the phase about to start
  always_comb begin
    strb_d = STROBE_IDLE;
    unique case (phase_d)
      PH_WSETUP: strb_d.cs_n = 1'b0;
      PH_WPULSE: begin
        strb_d.cs_n  = 1'b0;
        strb_d.we_n  = 1'b0;
        strb_d.drive = (cnt_d >= CNT_W'(WZ_CYC));
      end
      PH_WHOLD:  strb_d.drive = 1'b1;
      PH_RACCESS: begin
        strb_d.cs_n = 1'b0;
        strb_d.oe_n = 1'b0;
      end
      default: strb_d = STROBE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q     <= STROBE_IDLE;
      host_ready <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      host_rdata <= '0;
    end else begin
      strb_q     <= strb_d;
      host_ready <= finish;
      if (accept) mem_addr <= host_addr;
      if (accept && host_we) mem_dq_out <= host_wdata;
      if (capture) host_rdata <= mem_dq_in;
    end
  end

  assign mem_cs_n  = strb_q.cs_n;
  assign mem_we_n  = strb_q.we_n;
  assign mem_oe_n  = strb_q.oe_n;
  assign mem_dq_oe = strb_q.drive;

endmodule

// File: rtl/asram_ctrl.sv
// Asynchronous SRAM access controller, top level.
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 24,
  parameter int unsigned T_AS   = 1,  // address setup before write strobe falls
  parameter int unsigned T_WP   = 3,  // minimum write strobe low time
  parameter int unsigned T_WZ   = 2,  // memory bus release after write strobe falls
  parameter int unsigned T_DS   = 2,  // data setup before the write ends
  parameter int unsigned T_DH   = 1,  // address/data hold after the write ends
  parameter int unsigned T_RD   = 4,  // address-to-data access time
  parameter int unsigned T_OZ   = 1,  // memory bus release after output enable rises
  parameter int unsigned T_CYC  = 4   // minimum access cycle time
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned SU_LEN  = umax(1, T_AS);
  localparam int unsigned PW_LEN  = umax(T_WP, T_WZ + umax(1, T_DS));
  localparam int unsigned HD_MIN  = umax(1, T_DH);
  localparam int unsigned HD_LEN  = (T_CYC > SU_LEN + PW_LEN + HD_MIN)
                                    ? (T_CYC - SU_LEN - PW_LEN) : HD_MIN;
  localparam int unsigned RD_LEN  = umax(1, T_RD);
  localparam int unsigned GAP_MIN = umax(1, T_OZ);
  localparam int unsigned GAP_LEN = (T_CYC > RD_LEN + GAP_MIN) ? (T_CYC - RD_LEN) : GAP_MIN;
  localparam int unsigned MAX_LEN = umax(umax(umax(SU_LEN, PW_LEN), umax(HD_LEN, RD_LEN)), GAP_LEN);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  phase_e           phase_d;
  logic [CNT_W-1:0] cnt_d;
  logic             accept;
  logic             capture;
  logic             finish;

  asram_seq #(
    .SU_LEN  (SU_LEN),
    .PW_LEN  (PW_LEN),
    .HD_LEN  (HD_LEN),
    .RD_LEN  (RD_LEN),
    .GAP_LEN (GAP_LEN),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .req     (host_req),
    .req_we  (host_we),
    .phase_d (phase_d),
    .cnt_d   (cnt_d),
    .accept  (accept),
    .capture (capture),
    .finish  (finish)
  );

  asram_pin_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .WZ_CYC (T_WZ)
  ) u_pins (
    .clk        (clk),
    .rst        (rst),
    .phase_d    (phase_d),
    .cnt_d      (cnt_d),
    .accept     (accept),
    .capture    (capture),
    .finish     (finish),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mem_dq_in  (mem_dq_in),
    .host_rdata (host_rdata),
    .host_ready (host_ready),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
// Protocol checker bound to the controller top.
module asram_ctrl_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 24,
  parameter int unsigned T_WZ   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              host_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  // Clocks the write strobe has been low before the current one
  logic [7:0] wl_cnt;
  always_ff @(posedge clk) begin
    if (rst || mem_we_n) wl_cnt <= '0;
    else if (wl_cnt != 8'hFF) wl_cnt <= wl_cnt + 8'd1;
  end

  a_r10_deselect_masks: assert property (@(posedge clk) disable iff (rst)
    mem_cs_n |-> (mem_we_n && mem_oe_n));

  a_r3_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  a_r7_no_drive_vs_mem: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

  a_r7_gap_after_read: assert property (@(posedge clk) disable iff (rst)
    $past(!mem_oe_n) |-> !mem_dq_oe);

  a_r4_late_drive: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && (wl_cnt < 8'(T_WZ))) |-> !mem_dq_oe);

  a_r4_data_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  a_r5_joint_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> ($rose(mem_cs_n) && mem_dq_oe));

  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .T_WZ   (T_WZ)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_ready (host_ready),
  .mem_addr   (mem_addr),
  .mem_cs_n   (mem_cs_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  localparam int DW = 24;
  localparam int T_AS = 1, T_WP = 3, T_WZ = 2, T_DS = 2, T_DH = 1;
  localparam int T_RD = 4, T_OZ = 1, T_CYC = 4;
  localparam logic [DW-1:0] FLOAT = 24'h5A5A5A;

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int SU   = mx(1, T_AS);
  localparam int PW   = mx(T_WP, T_WZ + mx(1, T_DS));
  localparam int HD   = mx(mx(1, T_DH), T_CYC - SU - PW);
  localparam int RD   = mx(1, T_RD);
  localparam int GAP  = mx(mx(1, T_OZ), T_CYC - RD);
  localparam int WLEN = SU + PW + HD;
  localparam int RLEN = RD + GAP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_req = 1'b0;
  logic host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic host_ready;
  logic [AW-1:0] mem_addr;
  logic mem_cs_n, mem_we_n, mem_oe_n;
  logic [DW-1:0] mem_dq_out;
  logic mem_dq_oe;
  logic [DW-1:0] mem_dq_in = FLOAT;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [DW-1:0] model_mem [int];
  logic [DW-1:0] exp_mem [int];
  logic [DW-1:0] last_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WZ(T_WZ), .T_DS(T_DS),
    .T_DH(T_DH), .T_RD(T_RD), .T_OZ(T_OZ), .T_CYC(T_CYC)
  ) dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd_exp(input logic [AW-1:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : '0;
  endfunction

  // Expected {cs_n, we_n, oe_n, drive} in clock k (1-based) of an access
  function automatic logic [3:0] exp_pins(input bit wr, input int k);
    if (wr) begin
      if (k <= SU) return 4'b0110;
      if (k <= SU + PW) return ((k - SU - 1) >= T_WZ) ? 4'b0011 : 4'b0010;
      return 4'b1111;
    end
    if (k <= RD) return 4'b0100;
    return 4'b1110;
  endfunction

  // Memory model and bus monitor, evaluated between clock edges
  bit wl_prev = 0;
  int drv_in_wr = 0;
  int since_drv = 1000;
  logic [AW-1:0] wr_addr = '0;
  always @(negedge clk) begin
    if (rst) begin
      mem_dq_in = FLOAT;
      wl_prev = 0;
    end else begin : mon
      bit wl, mdrv;
      wl   = !mem_cs_n && !mem_we_n;
      mdrv = !mem_cs_n && !mem_oe_n && mem_we_n;
      if (wl && !wl_prev) begin
        drv_in_wr = 0;
        wr_addr = mem_addr;
      end
      if (wl) begin
        if (mem_dq_oe) drv_in_wr++;
        chk("R2", "address moved during write strobe", DW'(mem_addr), DW'(wr_addr));
      end
      if (wl_prev && !wl) begin
        // Write ended at the last edge: commit what is on the bus (R5)
        chk("R5", "drivers on at write end", DW'(mem_dq_oe), 24'd1);
        chk("R4", "data setup clocks met", DW'(drv_in_wr >= T_DS), 24'd1);
        model_mem[int'(wr_addr)] = mem_dq_oe ? mem_dq_out : FLOAT;
      end
      wl_prev = wl;
      if (mdrv) since_drv = 0;
      else if (since_drv < 1000) since_drv++;
      if (mem_dq_oe)
        chk("R7", "drive too soon after memory output", DW'(since_drv > T_OZ), 24'd1);
      if (mem_dq_oe) mem_dq_in = mem_dq_out;
      else if (mdrv) mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : '0;
      else mem_dq_in = FLOAT;
    end
  end

  // One complete access; poke injects a stray request mid-access (R9)
  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit poke, input string rtag);
    int n;
    n = wr ? WLEN : RLEN;
    @(negedge clk);
    chk("R8", "ready low between accesses", DW'(host_ready), 24'd0);
    host_req = 1'b1; host_we = wr; host_addr = a; host_wdata = d;
    @(negedge clk);
    for (int k = 1; k <= n + 1; k++) begin
      if (poke && k == 2) begin
        host_req = 1'b1; host_we = 1'b1; host_addr = ~a; host_wdata = ~d;
      end else begin
        host_req = 1'b0;
        host_we = 1'($urandom); host_addr = AW'($urandom); host_wdata = DW'($urandom);
      end
      if (k <= n) begin
        string tg;
        if (wr) tg = (k <= SU) ? "R2" : ((k <= SU + PW) ? "R3" : "R5");
        else    tg = (k <= RD) ? "R6" : "R7";
        chk(tg, "pins {cs_n,we_n,oe_n,oe}",
            DW'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), DW'(exp_pins(wr, k)));
        chk(tg, "address held", DW'(mem_addr), DW'(a));
        if (wr && mem_dq_oe) chk("R4", "driven write data", mem_dq_out, d);
        chk("R8", "no early ready", DW'(host_ready), 24'd0);
        @(negedge clk);
      end else begin
        chk("R8", "ready at end of access", DW'(host_ready), 24'd1);
        chk("R10", "idle strobes after access",
            DW'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 24'hE);
      end
    end
    host_req = 1'b0;
    if (wr) begin
      exp_mem[int'(a)] = d;
      chk("R6", "read word held across write", host_rdata, last_rd);
    end else begin
      last_rd = rd_exp(a);
      chk(rtag, "read data", host_rdata, last_rd);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "strobes during reset",
        DW'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, host_ready}), 24'h1C);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "strobes after reset",
        DW'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, host_ready}), 24'h1C);

    // Directed corners
    do_op(1, 15'h0000, 24'hFFFFFF, 0, "R6");
    do_op(1, 15'h7FFF, 24'h000001, 0, "R6");
    do_op(0, 15'h7FFF, '0, 0, "R6");
    do_op(0, 15'h0000, '0, 0, "R6");
    do_op(0, 15'h1234, '0, 0, "R6");           // unwritten location
    do_op(1, 15'h0100, 24'hABCDEF, 1, "R6");  // stray request mid-write
    do_op(0, 15'h7EFF, '0, 0, "R9");          // stray target stays unwritten
    do_op(0, 15'h0100, '0, 1, "R9");          // stray request mid-read
    do_op(0, 15'h7EFF, '0, 0, "R9");
    do_op(1, 15'h0100, 24'h13579B, 0, "R7");  // write right after read
    do_op(0, 15'h0100, '0, 0, "R7");

    // Constrained random mix over a small address pool
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = AW'((($urandom % 20) * 1237) + 3);
      do_op(1'($urandom), a, DW'($urandom), ($urandom % 8) == 0, "R6");
    end

    @(negedge clk);
    chk("R8", "ready single pulse", DW'(host_ready), 24'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule